// File: doc/BRIEF.md
# Dual-Mode Pixel Input Formatter

This block sits at the front of a display transmitter. It takes the parallel pixel bus from a graphics source and hands one complete 24-bit pixel per clock to the encoder stage that follows. Each pixel travels with three qualifiers: data enable, horizontal sync and vertical sync. The qualifiers stay lined up with their pixel. When data enable is high the output cycle carries an active pixel. When it is low the output is a blanking cycle, and the sync bits are what matter.

A mode input picks one of two capture schemes, and it can change at run time.

- **Wide mode.** All 24 input lines are sampled once, on the rising clock edge.
- **Narrow mode.** Only the low 12 lines carry pixel data. A half pixel is taken on the rising edge and another on the falling edge, and the two halves are joined. The upper input lines 23 to 16 are idle for pixel purposes in this mode. They are captured instead into an 8-bit configuration value, which a register interface elsewhere can read.

A valid strobe marks the clock cycles on which a new pixel is presented.

Top module: `pixel_in_fmt`

## Requirements
- R1: A synchronous reset, sampled on the rising edge, clears `pix_out`, `de_out`, `hs_out`, `vs_out` and `cfg_out` to zero and drives `valid_out` low. A reset seen on a falling edge also clears the stored falling-edge half.
- R2: With `wide_mode` high on a rising edge, the 24-bit value on `din` at that edge appears on `pix_out` right after the edge, and `valid_out` is high. Bits 23 to 12 of `din` form the upper half of the pixel and bits 11 to 0 the lower half.
- R3: In narrow mode (`wide_mode` low), `din[11:0]` taken at rising edge k becomes `pix_out[11:0]`. `din[11:0]` taken at the falling edge after k becomes `pix_out[23:12]`. The joined pixel appears with `valid_out` high right after rising edge k+1, provided edge k+1 is also in narrow mode.
- R4: On the first narrow-mode rising edge after reset, or after a wide-mode edge, no pixel is complete, and `valid_out` is low after that edge.
- R5: `de_out`, `hs_out` and `vs_out` carry the qualifier values sampled at the same rising edge as the pixel's first (or only) part. They therefore share the pixel's latency: one edge in wide mode, two edges in narrow mode.
- R6: A rising edge in wide mode throws away any half pixel taken at an earlier narrow-mode edge. The output after that edge is the full `din` value, never a joined pixel.
- R7: On every rising edge in narrow mode, `cfg_out` loads `din[23:16]`.
- R8: On a rising edge in wide mode, `cfg_out` keeps its previous value.
- R9: While `valid_out` is low, `pix_out` and the three qualifier outputs hold their previous values.
- R10: In narrow mode, `din[23:12]` never affects `pix_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; both edges used in narrow mode |
| rst | input | 1 | Synchronous reset, active high |
| wide_mode | input | 1 | 1 = 24-bit single-edge capture, 0 = 12-bit dual-edge capture |
| din | input | 24 | Parallel pixel input |
| de_in | input | 1 | Data enable in |
| hs_in | input | 1 | Horizontal sync in |
| vs_in | input | 1 | Vertical sync in |
| pix_out | output | 24 | Assembled pixel |
| de_out | output | 1 | Data enable, aligned with `pix_out` |
| hs_out | output | 1 | Horizontal sync, aligned with `pix_out` |
| vs_out | output | 1 | Vertical sync, aligned with `pix_out` |
| valid_out | output | 1 | A new pixel is present this cycle |
| cfg_out | output | 8 | Configuration byte taken from idle upper lines |

## Verification
The bench drives a different value on `din[11:0]` before every rising edge and before every falling edge. A design that swapped the halves, or took both halves on one edge, would therefore show the wrong 24-bit word.

It switches between modes in both directions in the middle of a stream.

- **Narrow to wide.** A design that kept the stale half would emit a joined pixel where a full-bus pixel belongs.
- **Wide to narrow.** A design that forgot the start-up gap would raise valid one cycle early, carrying garbage.

Random traffic on the upper lines in narrow mode catches any leak of those bits into the pixel. Watching `cfg_out` across wide stretches catches a configuration byte that is overwritten when it should hold. Qualifiers toggle every cycle, so an off-by-one delay between pixel and qualifiers shows at once.

// File: rtl/pixel_in_fmt.sv
`timescale 1ns/1ps
module pixel_in_fmt #(
  parameter int HALF_W = 12,
  parameter int CFG_W  = 8,
  localparam int PIX_W = 2*HALF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wide_mode,
  input  logic [PIX_W-1:0] din,
  input  logic             de_in,
  input  logic             hs_in,
  input  logic             vs_in,
  output logic [PIX_W-1:0] pix_out,
  output logic             de_out,
  output logic             hs_out,
  output logic             vs_out,
  output logic             valid_out,
  output logic [CFG_W-1:0] cfg_out
);
  localparam int CFG_LSB = PIX_W - CFG_W;

  logic [HALF_W-1:0] lo_q, hi_q;
  logic [2:0]        qual_q;
  logic              pend;
  logic [2:0]        qual_now;

  assign qual_now = {de_in, hs_in, vs_in};

  always_ff @(negedge clk) begin
    if (rst) hi_q <= '0;
    else     hi_q <= din[HALF_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q      <= '0;
      qual_q    <= '0;
      pend      <= 1'b0;
      pix_out   <= '0;
      {de_out, hs_out, vs_out} <= '0;
      valid_out <= 1'b0;
      cfg_out   <= '0;
    end else if (wide_mode) begin
      pend      <= 1'b0;
      pix_out   <= din;
      {de_out, hs_out, vs_out} <= qual_now;
      valid_out <= 1'b1;
    end else begin
      valid_out <= pend;
      if (pend) begin
        pix_out <= {hi_q, lo_q};
        {de_out, hs_out, vs_out} <= qual_q;
      end
      lo_q    <= din[HALF_W-1:0];
      qual_q  <= qual_now;
      pend    <= 1'b1;
      cfg_out <= din[PIX_W-1:CFG_LSB];
    end
  end

  AST_WIDE_PIXEL: assert property (@(posedge clk) disable iff (rst)
    wide_mode |=> (valid_out && pix_out == $past(din))); // R2

  AST_WIDE_QUAL: assert property (@(posedge clk) disable iff (rst)
    wide_mode |=> ({de_out, hs_out, vs_out} == $past(qual_now))); // R5

  AST_NARROW_LOW: assert property (@(posedge clk) disable iff (rst)
    (!wide_mode && !$past(wide_mode) && !$past(rst))
      |=> (valid_out && pix_out[HALF_W-1:0] == $past(din[HALF_W-1:0], 2))); // R3

  AST_NARROW_START: assert property (@(posedge clk) disable iff (rst)
    (!wide_mode && ($past(wide_mode) || $past(rst))) |=> !valid_out); // R4

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
    !wide_mode |=> (cfg_out == $past(din[PIX_W-1:CFG_LSB]))); // R7

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    wide_mode |=> $stable(cfg_out)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!valid_out && !$past(rst)) |-> ($stable(pix_out) && $stable(de_out) &&
                                     $stable(hs_out) && $stable(vs_out))); // R9
endmodule

// File: tb/pixel_in_fmt_tb_top.sv
`timescale 1ns/1ps
module pixel_in_fmt_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wide_mode = 1'b1;
  logic [23:0] din = '0;
  logic        de_in = 1'b0, hs_in = 1'b0, vs_in = 1'b0;
  logic [23:0] pix_out;
  logic        de_out, hs_out, vs_out, valid_out;
  logic [7:0]  cfg_out;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [23:0] e_pix = '0;
  logic [2:0]  e_q   = '0;
  logic        e_val = 1'b0;
  logic [7:0]  e_cfg = '0;
  logic [11:0] m_lo  = '0, m_hi = '0;
  logic [2:0]  m_q   = '0;
  logic        m_pend = 1'b0;

  always #5 clk = ~clk;

  pixel_in_fmt dut_i (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .din(din),
    .de_in(de_in), .hs_in(hs_in), .vs_in(vs_in),
    .pix_out(pix_out), .de_out(de_out), .hs_out(hs_out), .vs_out(vs_out),
    .valid_out(valid_out), .cfg_out(cfg_out)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_rise(input logic m, input logic [23:0] rv, input logic [2:0] q);
    if (rst) begin
      e_pix = '0; e_q = '0; e_val = 1'b0; e_cfg = '0;
      m_lo = '0; m_q = '0; m_pend = 1'b0;
    end else if (m) begin
      e_pix = rv; e_q = q; e_val = 1'b1; m_pend = 1'b0;
    end else begin
      e_val = m_pend;
      if (m_pend) begin
        e_pix = {m_hi, m_lo};
        e_q   = m_q;
      end
      m_lo = rv[11:0]; m_q = q; m_pend = 1'b1;
      e_cfg = rv[23:16];
    end
  endtask

  task automatic cyc(input logic m, input logic [23:0] rv, input logic [11:0] fv,
                     input logic [2:0] q, input string tag);
    wide_mode = m; din = rv; {de_in, hs_in, vs_in} = q;
    @(posedge clk);
    model_rise(m, rv, q);
    #1;
    check(tag, "pix", {8'h0, pix_out}, {8'h0, e_pix});
    check("R5", "qual", {29'h0, de_out, hs_out, vs_out}, {29'h0, e_q});
    check(tag, "valid", {31'h0, valid_out}, {31'h0, e_val});
    check(rst ? "R1" : (m ? "R8" : "R7"), "cfg", {24'h0, cfg_out}, {24'h0, e_cfg});
    din[11:0] = fv;
    @(negedge clk);
    if (rst) m_hi = '0; else m_hi = fv;
    #1;
  endtask

  function automatic logic [23:0] pat(input int i);
    return 24'hA5C31E ^ (24'h13579B * i) ^ (24'h0F0F0F << (i % 5));
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state, with busy inputs
    rst = 1'b1;
    for (int i = 0; i < 3; i++) cyc(i[0], pat(i), pat(i + 7)[11:0], i[2:0], "R1");
    rst = 1'b0;
    // R2 wide capture
    for (int i = 0; i < 8; i++) cyc(1'b1, pat(i + 20), pat(i + 40)[11:0], 3'(i * 3), "R2");
    // R4 entering narrow, then R3/R10 narrow stream
    cyc(1'b0, pat(60), pat(61)[11:0], 3'b101, "R4");
    for (int i = 0; i < 10; i++) cyc(1'b0, pat(i + 70), pat(i + 90)[11:0], 3'(i + 1), "R3");
    for (int i = 0; i < 4; i++) cyc(1'b0, pat(i + 110) ^ 24'hFFF000, pat(i + 120)[11:0], 3'(7 - i), "R10");
    // R6 narrow to wide discards pending half
    cyc(1'b1, pat(130), pat(131)[11:0], 3'b011, "R6");
    for (int i = 0; i < 4; i++) cyc(1'b1, pat(i + 140), pat(i + 150)[11:0], 3'(i), "R8");
    // R9 hold during the start-up gap, then alternate modes
    cyc(1'b0, pat(160), pat(161)[11:0], 3'b111, "R9");
    cyc(1'b0, pat(162), pat(163)[11:0], 3'b000, "R3");
    cyc(1'b1, pat(164), pat(165)[11:0], 3'b110, "R6");
    cyc(1'b0, pat(166), pat(167)[11:0], 3'b001, "R4");
    cyc(1'b1, pat(168), pat(169)[11:0], 3'b010, "R6");
    for (int i = 0; i < 20; i++)
      cyc(pat(i + 200)[3] & pat(i + 200)[9], pat(i + 210), pat(i + 230)[11:0], 3'(i * 5), "R3");
    // R1 reset in the middle of narrow mode
    cyc(1'b0, pat(260), pat(261)[11:0], 3'b100, "R3");
    rst = 1'b1;
    cyc(1'b0, pat(262), pat(263)[11:0], 3'b111, "R1");
    rst = 1'b0;
    cyc(1'b0, pat(264), pat(265)[11:0], 3'b010, "R4");
    for (int i = 0; i < 5; i++) cyc(1'b0, pat(i + 270), pat(i + 280)[11:0], 3'(i), "R3");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule